// File: doc/BRIEF.md
# Bucket-Brigade Sample Strobe Sequencer

This block produces the sample commands for a row of hold stages that are wired output to input. A trigger loads one single-bit token into a serial-in, parallel-out chain that advances on a slow shift tick. Every second stage of the chain drives one hold strobe. The taps are wired in reverse order, so the last hold stage in the row samples first and the first samples last. Each stage therefore hands its held value on before it takes a new one. Each strobe stays high for one tick period, and there is always at least one all-low tick between two strobes.

The trigger has two possible sources, chosen by a mode input:
- an internal period counter, counting in ticks;
- an external input, which is passed through a two-flop synchronizer and reduced to its rising edge.

A pending-token latch feeds the serial input. The latch is set by a trigger and cleared when the token enters the first stage, so one trigger launches exactly one token. A trigger that arrives while a token is still in flight is dropped. The shift tick comes from a divider on the system clock, and an enable input can pause it.

Top module: `bb_strobe_seq`

## Requirements
- R1: A synchronous active-high reset clears the pending-token latch, the shift chain, the tick divider, the internal period counter and the synchronizer. After the reset, all strobes are low and `busy` is low.
- R2: While `tick_en` is high, the chain advances by one stage every TICK_DIV clocks. While `tick_en` is low, the chain and the strobes hold their values.
- R3: One trigger sets the latch. The latch is cleared on the tick that moves the token into chain stage 1, so exactly one token enters the chain per accepted trigger.
- R4: The taps map to the strobes as follows: chain stage 2 drives `strobe[3]`, stage 4 drives `strobe[2]`, stage 6 drives `strobe[1]` and stage 8 drives `strobe[0]`. A token therefore raises the strobes in the order 3, 2, 1, 0.
- R5: With `tick_en` held high, each strobe is high for exactly TICK_DIV clocks (one tick period).
- R6: At most one strobe is high at any time. When a strobe falls, all strobes are low on the next cycle.
- R7: In external mode (`use_ext`=1), only a rising edge of the synchronized `ext_trig` is a trigger. An input held high launches only one token.
- R8: In internal mode (`use_ext`=0), a trigger fires once every `rate_ticks` ticks. A value of 0 is treated as 1.
- R9: In external mode the internal counter is held cleared and produces no triggers. In internal mode, `ext_trig` has no effect.
- R10: A trigger that arrives while `busy` is high is dropped and does not queue a second token.
- R11: `busy` is high exactly while a token is pending in the latch or sits in any chain stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Enables the shift-tick divider |
| ext_trig | input | 1 | Asynchronous external trigger |
| use_ext | input | 1 | 1 selects the external trigger, 0 selects the internal period counter |
| rate_ticks | input | RATE_W | Internal trigger period in ticks |
| strobe | output | N_HOLD | Sample strobes; bit k drives hold stage k+1 |
| busy | output | 1 | A token is pending or in flight |

## Verification
The assertions check the following on every cycle:
- at most one strobe is high;
- a falling strobe is followed by an all-low cycle;
- the strobes change only after a tick;
- any high strobe implies `busy`;
- the latch clears when the token leaves it;
- a trigger during `busy` cannot set the latch;
- the edge detector pulses for a single cycle.

Some behaviours can only be shown by the bench's scenarios, which compare against a behavioural token-position model:
- a held-high external input yields one token;
- the strobe order is 3, 2, 1, 0;
- each strobe is exactly one tick period wide;
- the internal period, including the zero-rate case, is correct;
- `tick_en` freezes the chain;
- mode switching ignores the unselected source.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  // Trigger source selection
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } trig_src_e;

  // Chain index (0-based, index 0 = stage 1) feeding strobe k.
  // Strobe k serves hold stage k+1; the last hold stage takes the
  // earliest even stage so the row updates from last to first.
  function automatic int unsigned tap_of(input int unsigned k,
                                         input int unsigned n_hold);
    return 2 * (n_hold - k) - 1;
  endfunction

endpackage

// File: rtl/bbs_tick_div.sv
module bbs_tick_div #(
  parameter int unsigned TICK_DIV = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (en) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/bbs_rate_gen.sv
module bbs_rate_gen #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_clr,
  input  logic              tick,
  input  logic [RATE_W-1:0] period,
  output logic              pulse
);
  logic [RATE_W-1:0] cnt;
  logic [RATE_W-1:0] last;

  // A period of zero behaves as one tick
  always_comb begin
    if (period == '0) last = '0;
    else              last = period - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || hold_clr) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (tick) begin
      if (cnt >= last) begin
        cnt   <= '0;
        pulse <= 1'b1;
      end else begin
        cnt   <= cnt + 1'b1;
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/bbs_trig_cond.sv
module bbs_trig_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  input  logic sel_ext,
  input  logic int_pulse,
  output logic ext_edge,
  output logic trig
);
  localparam int unsigned SW = SYNC_STAGES + 1;

  // sync[0..SYNC_STAGES-1] form the synchronizer; the extra flop
  // holds the previous synchronized level for edge detection.
  logic [SW-1:0] sync;

  always_ff @(posedge clk) begin
    if (rst) sync <= '0;
    else     sync <= {sync[SW-2:0], ext_in};
  end

  assign ext_edge = sync[SW-2] & ~sync[SW-1];

  always_ff @(posedge clk) begin
    if (rst) trig <= 1'b0;
    else     trig <= sel_ext ? ext_edge : int_pulse;
  end
endmodule

// File: rtl/bbs_token_chain.sv
module bbs_token_chain #(
  parameter int unsigned N_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              trig,
  output logic              pending,
  output logic [N_HOLD-1:0] strobe,
  output logic              busy
);
  import bbs_pkg::*;

  localparam int unsigned CHAIN = 2 * N_HOLD;

  logic [CHAIN-1:0] stage;

  assign busy = pending | (|stage);

  // Pending-token latch: set by an accepted trigger, cleared by the
  // tick that carries the token into stage 1.
  always_ff @(posedge clk) begin
    if (rst)                 pending <= 1'b0;
    else if (tick && pending) pending <= 1'b0;
    else if (trig && !busy)  pending <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       stage <= '0;
    else if (tick) stage <= {stage[CHAIN-2:0], pending};
  end

  for (genvar k = 0; k < N_HOLD; k++) begin : g_tap
    assign strobe[k] = stage[tap_of(k, N_HOLD)];
  end
endmodule

// File: rtl/bb_strobe_seq.sv
module bb_strobe_seq #(
  parameter int unsigned TICK_DIV    = 100000,
  parameter int unsigned RATE_W      = 16,
  parameter int unsigned N_HOLD      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              ext_trig,
  input  logic              use_ext,
  input  logic [RATE_W-1:0] rate_ticks,
  output logic [N_HOLD-1:0] strobe,
  output logic              busy
);
  import bbs_pkg::*;

  logic      tick;
  logic      int_pulse;
  logic      ext_edge;
  logic      trig;
  logic      pending;
  trig_src_e src;

  assign src = trig_src_e'(use_ext);

  bbs_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .en  (tick_en),
    .tick(tick)
  );

  bbs_rate_gen #(.RATE_W(RATE_W)) u_rate (
    .clk     (clk),
    .rst     (rst),
    .hold_clr(src == SRC_EXTERNAL),
    .tick    (tick),
    .period  (rate_ticks),
    .pulse   (int_pulse)
  );

  bbs_trig_cond #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk      (clk),
    .rst      (rst),
    .ext_in   (ext_trig),
    .sel_ext  (src == SRC_EXTERNAL),
    .int_pulse(int_pulse),
    .ext_edge (ext_edge),
    .trig     (trig)
  );

  bbs_token_chain #(.N_HOLD(N_HOLD)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .trig   (trig),
    .pending(pending),
    .strobe (strobe),
    .busy   (busy)
  );
endmodule

// File: rtl/bb_strobe_seq_chk.sv
module bb_strobe_seq_chk #(
  parameter int unsigned N_HOLD = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [N_HOLD-1:0] strobe,
  input logic              busy,
  input logic              tick,
  input logic              trig,
  input logic              pending,
  input logic              ext_edge
);
  // Becomes high two edges after a reset edge, so $past never sees
  // pre-reset values.
  logic seen1, live;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen1 <= 1'b1;
      live  <= 1'b0;
    end else begin
      live <= seen1;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (strobe == '0 && !busy));

  assert_moves_on_tick_R2: assert property (@(posedge clk) disable iff (rst || !live)
    !$past(tick) |-> $stable(strobe));

  assert_latch_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (pending && tick) |=> !pending);

  assert_one_hot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

  assert_gap_after_fall_R6: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(strobe) != '0 && strobe != $past(strobe)) |-> strobe == '0);

  assert_edge_single_R7: assert property (@(posedge clk) disable iff (rst)
    ext_edge |=> !ext_edge);

  assert_drop_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (trig && busy && !pending) |=> !pending);

  assert_strobe_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (strobe != '0) |-> busy);
endmodule

bind bb_strobe_seq bb_strobe_seq_chk #(.N_HOLD(N_HOLD)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .strobe  (strobe),
  .busy    (busy),
  .tick    (tick),
  .trig    (trig),
  .pending (pending),
  .ext_edge(ext_edge)
);

// File: tb/bb_strobe_seq_test.sv
`timescale 1ns/1ps
module bb_strobe_seq_test;
  localparam int unsigned TICK_DIV = 4;
  localparam int unsigned RATE_W   = 16;
  localparam int unsigned N_HOLD   = 4;
  localparam int CHAIN = 2 * N_HOLD;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_en = 1'b1;
  logic              ext_trig = 1'b0;
  logic              use_ext = 1'b0;
  logic [RATE_W-1:0] rate_ticks = 16'd0;
  logic [N_HOLD-1:0] strobe;
  logic              busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bb_strobe_seq #(.TICK_DIV(TICK_DIV), .RATE_W(RATE_W), .N_HOLD(N_HOLD)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ext_trig(ext_trig),
    .use_ext(use_ext), .rate_ticks(rate_ticks), .strobe(strobe), .busy(busy)
  );

  // Behavioural reference: tracks the token as a position
  // (-1 none, 0 pending, 1..CHAIN chain stage).
  int m_div, m_pcnt, m_pos;
  bit m_tick, m_s1, m_s2, m_s3, m_trig, m_ip;

  always @(posedge clk) begin
    bit nt;
    int per;
    if (rst) begin
      m_div = 0; m_pcnt = 0; m_pos = -1;
      m_tick = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_trig = 0; m_ip = 0;
    end else begin
      if (m_tick && m_pos >= 0) begin
        m_pos++;
        if (m_pos > CHAIN) m_pos = -1;
      end else if (m_trig && m_pos < 0) begin
        m_pos = 0;
      end
      nt = use_ext ? (m_s2 && !m_s3) : m_ip;
      if (use_ext) begin
        m_pcnt = 0; m_ip = 0;
      end else if (m_tick) begin
        per = (rate_ticks == 0) ? 1 : int'(rate_ticks);
        if (m_pcnt >= per - 1) begin m_pcnt = 0; m_ip = 1; end
        else begin m_pcnt++; m_ip = 0; end
      end else begin
        m_ip = 0;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_trig;
      m_trig = nt;
      if (tick_en) begin
        if (m_div == TICK_DIV - 1) begin m_div = 0; m_tick = 1; end
        else begin m_div++; m_tick = 0; end
      end else begin
        m_tick = 0;
      end
    end
  end

  function automatic logic [N_HOLD-1:0] exp_strobe(int pos);
    logic [N_HOLD-1:0] s = '0;
    for (int k = 0; k < N_HOLD; k++)
      if (pos == 2 * (N_HOLD - k)) s[k] = 1'b1;
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R4 taps, R11 busy)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(strobe == exp_strobe(m_pos), "R4 strobe vs model", strobe, exp_strobe(m_pos));
      check(busy == (m_pos >= 0), "R11 busy vs model", busy, m_pos >= 0);
    end
  end

  // Rise recorders
  int rises[N_HOLD];
  int order_q[$];
  logic [N_HOLD-1:0] prev_s = '0;
  always @(negedge clk) begin
    for (int k = 0; k < N_HOLD; k++)
      if (strobe[k] && !prev_s[k]) begin
        rises[k]++;
        order_q.push_back(k);
      end
    prev_s = strobe;
  end

  task automatic clr_counts();
    for (int k = 0; k < N_HOLD; k++) rises[k] = 0;
    order_q.delete();
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 2000) begin cyc(1); g++; end
  endtask

  initial begin
    #200000ns;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w;
    // R1: reset state
    cyc(3);
    check(strobe == '0, "R1 strobes after reset", strobe, 0);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    rst = 1'b0;

    // R8/R9: external mode, internal source must stay silent
    use_ext = 1'b1; rate_ticks = 16'd1;
    cyc(100);
    check(busy == 1'b0, "R9 internal ignored in ext mode", busy, 0);

    // R7, R4, R5: single external pulse -> one token, order 3,2,1,0
    clr_counts();
    ext_trig = 1'b1; cyc(3); ext_trig = 1'b0;
    while (!strobe[3]) cyc(1);
    w = 0;
    while (strobe[3]) begin cyc(1); w++; end
    check(w == TICK_DIV, "R5 strobe width", w, TICK_DIV);
    wait_idle(); cyc(5);
    check(rises[0] == 1, "R3 one token per trigger", rises[0], 1);
    check(order_q.size() == 4 && order_q[0] == 3 && order_q[3] == 0,
          "R4 order last-first", order_q.size() > 0 ? order_q[0] : -1, 3);
    check(order_q.size() == 4 && order_q[1] == 2 && order_q[2] == 1,
          "R6 distinct strobes in order", order_q.size(), 4);

    // R7: held-high external input gives one token
    clr_counts();
    ext_trig = 1'b1; cyc(200);
    check(rises[3] == 1, "R7 held high one token", rises[3], 1);
    ext_trig = 1'b0; wait_idle(); cyc(5);

    // R10: second edge while busy is dropped
    clr_counts();
    ext_trig = 1'b1; cyc(3); ext_trig = 1'b0; cyc(6);
    ext_trig = 1'b1; cyc(3); ext_trig = 1'b0;
    wait_idle(); cyc(10);
    check(rises[0] == 1, "R10 trigger while busy dropped", rises[0], 1);

    // R2: tick_en low freezes the chain mid-flight
    ext_trig = 1'b1; cyc(3); ext_trig = 1'b0;
    while (!strobe[2]) cyc(1);
    tick_en = 1'b0; cyc(40);
    check(strobe == 4'b0100, "R2 frozen with tick_en low", strobe, 4);
    tick_en = 1'b1; wait_idle(); cyc(5);

    // R8/R9: internal mode with period 20, external toggling ignored
    clr_counts();
    use_ext = 1'b0; rate_ticks = 16'd20;
    for (int i = 0; i < 20; i++) begin ext_trig = ~ext_trig; cyc(17); end
    ext_trig = 1'b0;
    check(rises[0] >= 3, "R8 internal period launches tokens", rises[0], 4);
    // R8: rate 0 acts as 1, back-to-back tokens, drops while busy
    clr_counts();
    rate_ticks = 16'd0; cyc(400);
    check(rises[0] >= 8, "R8 zero rate runs continuously", rises[0], 10);

    // R1: reset mid-flight clears everything
    cyc(13);
    rst = 1'b1; cyc(2);
    check(strobe == '0 && busy == 1'b0, "R1 reset mid-flight", {busy, strobe}, 0);
    rst = 1'b0; use_ext = 1'b1; cyc(20);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule